// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer with Byte Masking

This block is the data-phase engine for one open row of a synchronous DRAM. Read and write commands arrive with a starting column. The block then steps through the burst one column per clock, and the burst length is sampled with each command. For writes it reports which bytes are accepted in each beat, and the first beat is the command cycle itself. For reads it launches data a programmable CAS latency later and drives a per-byte output enable for the data bus.

Per-byte DQM behaves differently in the two directions. On writes a DQM bit suppresses its byte in the cycle it is sampled. On reads the same bit turns the byte's output off two cycles after it is sampled, whatever the CAS latency. A new read or write can break into a running burst. This lets back-to-back bursts run with no idle beat. A precharge stops column issue. A burst stop ends only full-page bursts, which otherwise keep cycling around the row.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset no beat, write enable, read launch or bus drive is active, and the CAS latency is 3.
- R2: A read beat issued in cycle t has its data launched (`rd_vld`, `rd_col`) in cycle t+CL, and the beats of a burst come on consecutive cycles.
- R3: `bl_code` selects the burst length: 0→1, 1→2, 2→4, 3→8, 7→full page, and any other code gives 1. Column addresses stay inside the aligned block of that many columns. The low bits count up and wrap while the high bits hold.
- R4: A read or write command in any cycle starts a new burst at once and abandons the old one, so bursts can follow each other with no gap.
- R5: A precharge in a cycle with no read or write stops column issue in that cycle. Read data already issued is still launched.
- R6: A write's first beat is in the command cycle. Write enable ends after the programmed number of beats.
- R7: A full-page burst wraps from the last column of the row to column 0 until a burst stop. A burst stop has no effect on bursts of lengths 1 to 8.
- R8: `bus_oe[i]` is low for a launched read beat when `dqm[i]` was high two cycles earlier, for CAS latency 2 and 3 alike.
- R9: During a write beat, `wr_be[i]` is the inverse of `dqm[i]` in the same cycle.
- R10: A write command discards all pending read launches, including one due in that cycle, so `rd_vld` and `wr_en` are never high together.
- R11: `cl_load` takes `cl_val` only when it is 2 or 3. Other values leave the latency unchanged.
- R12: When commands coincide, write wins over read, read over precharge, and precharge over burst stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_pre | input | 1 | Precharge of this bank |
| cmd_stop | input | 1 | Burst stop |
| col_in | input | COL_W | Start column of a command |
| dqm | input | LANES | Per-byte mask |
| bl_code | input | 3 | Burst length code, sampled with a command |
| cl_load | input | 1 | Load strobe for the CAS latency |
| cl_val | input | 2 | New CAS latency |
| beat_vld | output | 1 | A column beat is issued this cycle |
| beat_col | output | COL_W | Column of the current beat |
| wr_en | output | 1 | Write data is captured this cycle |
| wr_be | output | LANES | Byte enables of the captured write data |
| rd_vld | output | 1 | Read data is launched this cycle |
| rd_col | output | COL_W | Column whose data is launched |
| bus_oe | output | LANES | Per-byte data bus drive enable |

## Verification
The hardest state to reach is a write that lands while read data is still in flight. Reaching it needs a live burst in the latency pipeline, so the stimulus issues an 8-beat read at latency 3 and a write two cycles later. That write must discard launches already scheduled. Full-page wrap past the last column is another hard case. The bench starts a full-page read a few columns below the top of the row and holds it until it wraps, then stops it. A long stretch of mixed random commands, lengths and masks runs against the cycle model to cover overlaps the directed cases miss.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

  typedef enum logic [2:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd7
  } bl_code_e;

  localparam int MAX_COL_W = 16;
  localparam int MASK_LAT  = 2;   // read-side DQM delay in cycles
  localparam int MAX_CL    = 3;

  // low-bit mask of the aligned wrap block for a length code
  function automatic logic [15:0] block_mask(input logic [2:0] code);
    case (code)
      3'd1:    return 16'h0001;
      3'd2:    return 16'h0003;
      3'd3:    return 16'h0007;
      3'd7:    return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  // beats still to come once the first beat of a burst is issued
  function automatic logic [3:0] beats_after_first(input logic [2:0] code);
    case (code)
      3'd1:    return 4'd1;
      3'd2:    return 4'd3;
      3'd3:    return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  // next column: high bits held, low bits count and wrap
  function automatic logic [15:0] step_in_block(input logic [15:0] col,
                                                input logic [15:0] msk);
    return (col & ~msk) | ((col + 16'd1) & msk);
  endfunction

  function automatic logic cl_legal(input logic [1:0] v);
    return (v == 2'd2) || (v == 2'd3);
  endfunction

endpackage

// File: rtl/sdr_cl_cfg.sv
module sdr_cl_cfg
  import sdr_burst_pkg::*;
#(
  parameter int CL_W     = 2,
  parameter int CL_RESET = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CL_W-1:0] val,
  output logic [CL_W-1:0] cl
);

  logic            take;
  logic [CL_W-1:0] cl_q;

  assign take = load && cl_legal(val);
  assign cl   = cl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cl_q <= CL_W'(CL_RESET);
    else if (take) cl_q <= val;
  end

  assert_cl_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cl == 2'd2) || (cl == 2'd3));

  assert_cl_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (val != 2'd2) && (val != 2'd3)) |=> $stable(cl));

endmodule

// File: rtl/sdr_col_walker.sv
module sdr_col_walker
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_pre,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] col_in,
  input  logic [2:0]       bl_code,
  output logic             burst_start,
  output logic             beat_vld,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_col
);

  logic             act_q, wr_q, fp_q;
  logic [COL_W-1:0] col_q, msk_q;
  logic [CNT_W-1:0] left_q;

  logic             start, halt, cur_fp;
  logic [COL_W-1:0] cur_msk;
  logic [CNT_W-1:0] cur_rem;
  logic [15:0]      msk_w, col_w, mpad_w, nxt_w;

  always_comb begin
    start    = cmd_rd | cmd_wr;
    halt     = cmd_pre | (cmd_stop & fp_q);
    msk_w    = block_mask(bl_code);
    beat_vld = start | (act_q & ~halt);
    beat_wr  = start ? cmd_wr : wr_q;
    beat_col = start ? col_in : col_q;
    cur_fp   = start ? (bl_code == BL_PAGE) : fp_q;
    cur_msk  = start ? msk_w[COL_W-1:0] : msk_q;
    cur_rem  = start ? CNT_W'(beats_after_first(bl_code)) : (left_q - CNT_W'(1));
    col_w    = '0;
    col_w[COL_W-1:0] = beat_col;
    mpad_w   = '0;
    mpad_w[COL_W-1:0] = cur_msk;
    nxt_w    = step_in_block(col_w, mpad_w);
  end

  assign burst_start = start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      fp_q   <= 1'b0;
      col_q  <= '0;
      msk_q  <= '0;
      left_q <= '0;
    end else if (beat_vld) begin
      act_q  <= cur_fp | (cur_rem != '0);
      wr_q   <= beat_wr;
      fp_q   <= cur_fp;
      col_q  <= nxt_w[COL_W-1:0];
      msk_q  <= cur_msk;
      left_q <= cur_rem;
    end else begin
      act_q  <= 1'b0;
    end
  end

  assert_wrap_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !start && act_q) |->
      (((beat_col & ~msk_q) == ($past(beat_col) & ~msk_q)) &&
       ((beat_col & msk_q) == (($past(beat_col) + 1'b1) & msk_q))));

  assert_stop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !fp_q && cmd_stop && !cmd_pre && !start) |-> beat_vld);

endmodule

// File: rtl/sdr_rd_launch.sv
module sdr_rd_launch
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int LANES = 4,
  parameter int CL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [COL_W-1:0] issue_col,
  input  logic             flush,
  input  logic [CL_W-1:0]  cl,
  input  logic [LANES-1:0] dqm_in,
  output logic             rd_vld,
  output logic [COL_W-1:0] rd_col,
  output logic [LANES-1:0] bus_oe
);

  logic [MAX_CL:1]  vld_p;
  logic [COL_W-1:0] col_p [MAX_CL:1];
  logic [LANES-1:0] dqm_p [MASK_LAT:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_p <= '0;
      for (int k = 1; k <= MAX_CL; k++)   col_p[k] <= '0;
      for (int k = 1; k <= MASK_LAT; k++) dqm_p[k] <= '0;
    end else begin
      vld_p[1] <= issue & ~flush;
      col_p[1] <= issue_col;
      for (int k = 2; k <= MAX_CL; k++) begin
        vld_p[k] <= vld_p[k-1] & ~flush;
        col_p[k] <= col_p[k-1];
      end
      dqm_p[1] <= dqm_in;
      for (int k = 2; k <= MASK_LAT; k++) dqm_p[k] <= dqm_p[k-1];
    end
  end

  assign rd_vld = vld_p[cl] & ~flush;
  assign rd_col = col_p[cl];
  assign bus_oe = rd_vld ? ~dqm_p[MASK_LAT] : '0;

  assert_rd_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> (bus_oe == ~$past(dqm_in, 2)));

  assert_rd_lat2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && cl == 2'd2) |-> $past(issue, 2));

  assert_rd_lat3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && cl == 2'd3) |-> $past(issue, 3));

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_burst_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int LANES = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_pre,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] col_in,
  input  logic [LANES-1:0] dqm,
  input  logic [2:0]       bl_code,
  input  logic             cl_load,
  input  logic [1:0]       cl_val,
  output logic             beat_vld,
  output logic [COL_W-1:0] beat_col,
  output logic             wr_en,
  output logic [LANES-1:0] wr_be,
  output logic             rd_vld,
  output logic [COL_W-1:0] rd_col,
  output logic [LANES-1:0] bus_oe
);

  localparam int CL_W = 2;

  logic            burst_start, beat_wr, rd_issue, wr_start;
  logic [CL_W-1:0] cl;

  sdr_cl_cfg #(.CL_W(CL_W), .CL_RESET(MAX_CL)) u_cl (
    .clk(clk), .rst_n(rst_n), .load(cl_load), .val(cl_val), .cl(cl)
  );

  sdr_col_walker #(.COL_W(COL_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_pre(cmd_pre), .cmd_stop(cmd_stop), .col_in(col_in),
    .bl_code(bl_code), .burst_start(burst_start), .beat_vld(beat_vld),
    .beat_wr(beat_wr), .beat_col(beat_col)
  );

  assign rd_issue = beat_vld & ~beat_wr;
  assign wr_start = burst_start & cmd_wr;
  assign wr_en    = beat_vld & beat_wr;
  assign wr_be    = wr_en ? ~dqm : '0;

  sdr_rd_launch #(.COL_W(COL_W), .LANES(LANES), .CL_W(CL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .issue(rd_issue), .issue_col(beat_col),
    .flush(wr_start), .cl(cl), .dqm_in(dqm), .rd_vld(rd_vld),
    .rd_col(rd_col), .bus_oe(bus_oe)
  );

  assert_no_bus_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (rd_vld || (bus_oe != '0))));

  assert_wr_first_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (wr_en && beat_col == col_in));

endmodule

// File: tb/sdr_burst_seq_test.sv
`timescale 1ns/1ps
module sdr_burst_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, cmd_stop = 0;
  logic [7:0] col_in = '0;
  logic [3:0] dqm = '0;
  logic [2:0] bl_code = '0;
  logic       cl_load = 0;
  logic [1:0] cl_val = '0;
  logic       beat_vld, wr_en, rd_vld;
  logic [7:0] beat_col, rd_col;
  logic [3:0] wr_be, bus_oe;

  always #2 clk = ~clk;   // 250 MHz

  sdr_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_pre(cmd_pre), .cmd_stop(cmd_stop), .col_in(col_in), .dqm(dqm),
    .bl_code(bl_code), .cl_load(cl_load), .cl_val(cl_val),
    .beat_vld(beat_vld), .beat_col(beat_col), .wr_en(wr_en), .wr_be(wr_be),
    .rd_vld(rd_vld), .rd_col(rd_col), .bus_oe(bus_oe)
  );

  int    checks = 0, failures = 0, cyc = 0;
  string req = "R1";
  bit    done = 0;
  bit    e_rv [0:8191];
  int    e_rc [0:8191];
  int    dq_hist [0:8191];

  // reference state
  bit m_act = 0, m_wr = 0, m_fp = 0;
  int m_col = 0, m_msk = 0, m_left = 0, m_cl = 3;
  // inputs applied at the next tick
  int nx_bl = 0, nx_val = 0;
  bit nx_load = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h cyc=%0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int len_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  task automatic tick(bit rd, bit wr, bit pre, bit stp, int col, int dq);
    bit cv, cw, fp;
    int cc, msk, rem, ob;
    @(negedge clk);
    cmd_rd = rd; cmd_wr = wr; cmd_pre = pre; cmd_stop = stp;
    col_in = col[7:0]; dqm = dq[3:0]; bl_code = nx_bl[2:0];
    cl_load = nx_load; cl_val = nx_val[1:0];
    #1;
    cv = 0; cw = 0; fp = 0; cc = 0; msk = 0; rem = 0;
    if (rd || wr) begin                      // R12: write beats read
      cv = 1; cw = wr; cc = col & 255; fp = (nx_bl == 7);
      msk = fp ? 255 : len_of(nx_bl) - 1; rem = len_of(nx_bl) - 1;
    end else if (m_act && !(pre || (stp && m_fp))) begin
      cv = 1; cw = m_wr; cc = m_col; msk = m_msk; fp = m_fp; rem = m_left - 1;
    end
    if (wr) for (int k = cyc; k <= cyc + 4; k++) e_rv[k] = 0;
    dq_hist[cyc] = dq & 15;
    chk(req, "beat_vld", beat_vld, cv);
    if (cv) chk(req, "beat_col", beat_col, cc);
    chk(req, "wr_en", wr_en, cv && cw);
    chk(req, "wr_be", wr_be, (cv && cw) ? (~dq & 15) : 0);
    chk(req, "rd_vld", rd_vld, e_rv[cyc]);
    if (e_rv[cyc]) chk(req, "rd_col", rd_col, e_rc[cyc]);
    ob = e_rv[cyc] ? (~((cyc >= 2) ? dq_hist[cyc-2] : 0) & 15) : 0;
    chk(req, "bus_oe", bus_oe, ob);
    chk("R10", "clash", int'(wr_en && (rd_vld || bus_oe != 0)), 0);
    if (cv && !cw) begin e_rv[cyc + m_cl] = 1; e_rc[cyc + m_cl] = cc; end
    if (cv) begin
      m_col = ((cc & ~msk) | ((cc + 1) & msk)) & 255;
      m_left = rem; m_act = fp || (rem > 0);
      m_wr = cw; m_fp = fp; m_msk = msk;
    end else m_act = 0;
    if (nx_load && (nx_val == 2 || nx_val == 3)) m_cl = nx_val;
    cyc++;
  endtask

  task automatic idle(int n);
    repeat (n) tick(0, 0, 0, 0, 0, 0);
  endtask

  task automatic load_cl(int v);
    nx_load = 1; nx_val = v; tick(0, 0, 0, 0, 0, 0); nx_load = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: quiet after reset, latency 3
    req = "R1"; idle(3);
    // R2: latency 3 then latency 2
    req = "R2"; nx_bl = 2; tick(1, 0, 0, 0, 8'h10, 0); idle(7);
    load_cl(2); tick(1, 0, 0, 0, 8'h20, 0); idle(7);
    // R11: illegal values keep latency 2, then a legal 3
    req = "R11"; load_cl(0); load_cl(1); tick(1, 0, 0, 0, 8'h30, 0); idle(6);
    load_cl(3); tick(1, 0, 0, 0, 8'h34, 0); idle(6);
    // R3: every length, unaligned starts
    req = "R3"; nx_bl = 3; tick(1, 0, 0, 0, 8'h25, 0); idle(11);
    nx_bl = 1; tick(1, 0, 0, 0, 8'h33, 0); idle(5);
    nx_bl = 2; tick(1, 0, 0, 0, 8'h3E, 0); idle(6);
    nx_bl = 0; tick(1, 0, 0, 0, 8'h47, 0); idle(5);
    nx_bl = 5; tick(1, 0, 0, 0, 8'h49, 0); idle(5);
    // R6 and R9: write burst with varying masks
    req = "R6"; nx_bl = 2; tick(0, 1, 0, 0, 8'h42, 4'h0); idle(5);
    req = "R9"; tick(0, 1, 0, 0, 8'h51, 4'h5); tick(0, 0, 0, 0, 0, 4'hA);
    tick(0, 0, 0, 0, 0, 4'hF); tick(0, 0, 0, 0, 0, 4'h1); idle(3);
    // R4: interrupts and gapless chaining
    req = "R4"; nx_bl = 2; tick(1, 0, 0, 0, 8'h60, 0); idle(1);
    tick(1, 0, 0, 0, 8'h70, 0); idle(3); tick(1, 0, 0, 0, 8'h80, 0); idle(7);
    tick(0, 1, 0, 0, 8'h90, 0); idle(1); tick(0, 1, 0, 0, 8'h98, 0); idle(2);
    tick(1, 0, 0, 0, 8'hA0, 0); idle(7);
    // R10: write lands while read data is in flight
    req = "R10"; nx_bl = 3; tick(1, 0, 0, 0, 8'hB0, 0); idle(1);
    tick(0, 1, 0, 0, 8'hC0, 4'h3); idle(10);
    // R5: precharge cuts read and write bursts
    req = "R5"; tick(1, 0, 0, 0, 8'hD0, 0); idle(2); tick(0, 0, 1, 0, 0, 0); idle(6);
    tick(0, 1, 0, 0, 8'hD8, 0); idle(1); tick(0, 0, 1, 0, 0, 0); idle(4);
    // R7: full-page wrap and stop; stop ignored at length 8
    req = "R7"; nx_bl = 7; tick(1, 0, 0, 0, 8'hFC, 0); idle(9);
    tick(0, 0, 0, 1, 0, 0); idle(5);
    tick(0, 1, 0, 0, 8'hFE, 0); idle(4); tick(0, 0, 0, 1, 0, 0); idle(2);
    nx_bl = 3; tick(1, 0, 0, 0, 8'h10, 0); idle(2); tick(0, 0, 0, 1, 0, 0); idle(9);
    // R8: read masks, latency 3 then 2
    req = "R8"; nx_bl = 3; tick(1, 0, 0, 0, 8'h18, 4'h1);
    for (int k = 0; k < 9; k++) tick(0, 0, 0, 0, 0, (k * 5) & 15);
    idle(3); load_cl(2); tick(1, 0, 0, 0, 8'h28, 4'hC);
    for (int k = 0; k < 9; k++) tick(0, 0, 0, 0, 0, (k * 3) & 15);
    idle(3);
    // R12: coinciding commands
    req = "R12"; nx_bl = 2; tick(1, 1, 0, 0, 8'h44, 0); idle(5);
    tick(1, 0, 1, 1, 8'h48, 0); idle(6);
    nx_bl = 7; tick(1, 0, 0, 0, 8'h50, 0); idle(2); tick(0, 0, 1, 1, 0, 0); idle(4);
    // R4: mixed random traffic against the model
    req = "R4";
    for (int k = 0; k < 1200; k++) begin
      int r, code;
      r = $urandom_range(0, 99);
      code = $urandom_range(0, 5);
      nx_bl = (code == 4) ? 7 : ((code == 5) ? 6 : code);
      tick(r < 12, r >= 12 && r < 20, r >= 20 && r < 24, r >= 24 && r < 30,
           $urandom_range(0, 255), $urandom_range(0, 15));
    end
    idle(6);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule